// File: doc/BRIEF.md
# Branch and Jump Next-PC Unit

This combinational unit selects the address of the next instruction for a 32-bit RISC-V style core. Each cycle it takes the current program counter, the instruction word and the two source register values. It recognises the conditional branch, direct jump and register-indirect jump opcodes and assembles the branch and jump offsets from their scattered instruction bits. For a branch it evaluates the compare condition. It then presents the next PC, a flag that reports a redirect, the return address and a write enable for the return address.

Any other instruction falls through to the sequential address. The unit holds no state and has no handshake, because all of its pins are control values that are valid in the same cycle as its inputs. The fetch stage feeds `next_pc_o` back into its PC register. The writeback stage uses `link_val_o` when `link_we_o` is high.

Top module: `npc_unit`

## Requirements
- R1: When the opcode (instruction bits 6:0) is not 1100011, 1101111 or 1100111, `next_pc_o` is PC+4, `taken_o` is 0 and `link_we_o` is 0.
- R2: Opcode 1101111 sets `next_pc_o` to PC plus a sign-extended 21-bit offset, sets `taken_o` to 1, and sets `link_val_o` to PC+4. Offset bit 20 comes from instruction bit 31, offset bits 19:12 from instruction bits 19:12, offset bit 11 from instruction bit 20, offset bits 10:1 from instruction bits 30:21, and offset bit 0 is zero.
- R3: Opcode 1100111 with funct3 (bits 14:12) equal to 000 sets `next_pc_o` to rs1 plus the sign-extended offset in instruction bits 31:20, with bit 0 of the sum forced to 0, and sets `taken_o` to 1. With any other funct3 value, the instruction is handled as in R1.
- R4: For opcode 1100011, funct3 000 is taken when rs1 equals rs2, and funct3 001 is taken when rs1 differs from rs2.
- R5: For opcode 1100011, funct3 100 is taken when rs1 is less than rs2 as two's-complement values, and funct3 101 is taken when rs1 is greater than or equal to rs2 as two's-complement values.
- R6: For opcode 1100011, funct3 110 is taken when rs1 is less than rs2 as unsigned values, and funct3 111 is taken when rs1 is greater than or equal to rs2 as unsigned values.
- R7: For opcode 1100011, funct3 010 and 011 are never taken, and `next_pc_o` is PC+4.
- R8: A taken branch sets `next_pc_o` to PC plus a sign-extended 13-bit offset. Offset bit 12 comes from instruction bit 31, offset bit 11 from instruction bit 7, offset bits 10:5 from instruction bits 30:25, offset bits 4:1 from instruction bits 11:8, and offset bit 0 is zero. A branch that is not taken gives PC+4. `taken_o` equals the branch outcome.
- R9: `link_we_o` is 1 only for the jumps of R2 and R3 whose destination field (bits 11:7) is nonzero. `link_val_o` is always PC+4.
- R10: All address arithmetic wraps modulo 2^XLEN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pc_i | input | XLEN | Address of the current instruction |
| instr_i | input | 32 | Current instruction word |
| rs1_val_i | input | XLEN | First source register value |
| rs2_val_i | input | XLEN | Second source register value |
| next_pc_o | output | XLEN | Address of the next instruction |
| taken_o | output | 1 | Flow leaves the sequential path |
| link_val_o | output | XLEN | Return address (PC+4) |
| link_we_o | output | 1 | Write enable for the return address |

## Verification
The bench builds the unit with the default XLEN of 32. At that width a PC near the top of the address space makes the wrap of R10 reachable for both the sequential and the jump paths. Instructions are assembled in the bench from chosen offsets, so the extreme offsets are driven directly: the most negative branch offset of -4096, the largest even branch offset of +4094, and a jump offset that sets every middle field. The operands include values whose signed and unsigned orderings disagree (all ones against one), which separates R5 from R6.

// File: rtl/npc_pkg.sv
package npc_pkg;
  localparam logic [6:0] OP_BRANCH = 7'b1100011;
  localparam logic [6:0] OP_JAL    = 7'b1101111;
  localparam logic [6:0] OP_JALR   = 7'b1100111;

  typedef enum logic [2:0] {
    CMP_EQ   = 3'b000,
    CMP_NE   = 3'b001,
    CMP_RSV2 = 3'b010,
    CMP_RSV3 = 3'b011,
    CMP_LT   = 3'b100,
    CMP_GE   = 3'b101,
    CMP_LTU  = 3'b110,
    CMP_GEU  = 3'b111
  } cmp_e;

  typedef enum logic [1:0] {
    FLOW_SEQ,
    FLOW_BRANCH,
    FLOW_JAL,
    FLOW_JALR
  } flow_e;
endpackage

// File: rtl/npc_imm_gen.sv
module npc_imm_gen #(
  parameter int XLEN = 32
) (
  input  logic [31:7]     ifield_i,
  output logic [XLEN-1:0] imm_b_o,
  output logic [XLEN-1:0] imm_j_o,
  output logic [XLEN-1:0] imm_i_o
);
  localparam int BW = 13;
  localparam int JW = 21;
  localparam int IW = 12;

  logic [BW-1:0] raw_b;
  logic [JW-1:0] raw_j;
  logic [IW-1:0] raw_i;

  // offsets are reassembled from their scattered fields; bit 31 is the sign
  assign raw_b = {ifield_i[31], ifield_i[7], ifield_i[30:25], ifield_i[11:8], 1'b0};
  assign raw_j = {ifield_i[31], ifield_i[19:12], ifield_i[20], ifield_i[30:21], 1'b0};
  assign raw_i = ifield_i[31:20];

  assign imm_b_o = {{(XLEN-BW){raw_b[BW-1]}}, raw_b};
  assign imm_j_o = {{(XLEN-JW){raw_j[JW-1]}}, raw_j};
  assign imm_i_o = {{(XLEN-IW){raw_i[IW-1]}}, raw_i};

  always_comb begin
    // R8
    imm_b_sign_chk: assert (imm_b_o[XLEN-1] == ifield_i[31])
      else $error("branch offset sign differs from instruction bit 31");
    // R2
    imm_j_sign_chk: assert (imm_j_o[XLEN-1] == ifield_i[31])
      else $error("jump offset sign differs from instruction bit 31");
  end
endmodule

// File: rtl/npc_cmp.sv
module npc_cmp
  import npc_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] lhs_i,
  input  logic [XLEN-1:0] rhs_i,
  input  cmp_e            mode_i,
  output logic            hit_o
);
  localparam int MSB = XLEN - 1;

  logic same, below_u, below_s;

  assign same    = (lhs_i == rhs_i);
  assign below_u = (lhs_i < rhs_i);
  assign below_s = ($signed(lhs_i) < $signed(rhs_i));

  always_comb begin
    unique case (mode_i)
      CMP_EQ:  hit_o = same;
      CMP_NE:  hit_o = !same;
      CMP_LT:  hit_o = below_s;
      CMP_GE:  hit_o = !below_s;
      CMP_LTU: hit_o = below_u;
      CMP_GEU: hit_o = !below_u;
      default: hit_o = 1'b0;
    endcase
  end

  always_comb begin
    // R5
    signed_lt_chk: assert (!(mode_i == CMP_LT && lhs_i[MSB] != rhs_i[MSB])
                           || hit_o == lhs_i[MSB])
      else $error("signed compare ignores operand signs");
    // R6
    unsigned_ge_chk: assert (!(mode_i == CMP_GEU && lhs_i[MSB] != rhs_i[MSB])
                             || hit_o == lhs_i[MSB])
      else $error("unsigned compare mishandles top bit");
    // R7
    rsv_cmp_chk: assert (!(mode_i == CMP_RSV2 || mode_i == CMP_RSV3) || !hit_o)
      else $error("reserved compare code reported a hit");
  end
endmodule

// File: rtl/npc_unit.sv
module npc_unit
  import npc_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] pc_i,
  input  logic [31:0]     instr_i,
  input  logic [XLEN-1:0] rs1_val_i,
  input  logic [XLEN-1:0] rs2_val_i,
  output logic [XLEN-1:0] next_pc_o,
  output logic            taken_o,
  output logic [XLEN-1:0] link_val_o,
  output logic            link_we_o
);
  localparam logic [XLEN-1:0] STEP = XLEN'(4);

  logic [6:0]      opcode;
  logic [2:0]      funct3;
  logic [4:0]      rd;
  flow_e           flow;
  logic [XLEN-1:0] imm_b, imm_j, imm_i;
  logic [XLEN-1:0] seq_pc, target, ind_sum;
  logic            cond_hit;

  assign opcode = instr_i[6:0];
  assign funct3 = instr_i[14:12];
  assign rd     = instr_i[11:7];

  always_comb begin
    flow = FLOW_SEQ;
    unique case (opcode)
      OP_BRANCH: flow = FLOW_BRANCH;
      OP_JAL:    flow = FLOW_JAL;
      OP_JALR:   flow = (funct3 == 3'b000) ? FLOW_JALR : FLOW_SEQ;
      default:   flow = FLOW_SEQ;
    endcase
  end

  npc_imm_gen #(.XLEN(XLEN)) u_imm (
    .ifield_i (instr_i[31:7]),
    .imm_b_o  (imm_b),
    .imm_j_o  (imm_j),
    .imm_i_o  (imm_i)
  );

  npc_cmp #(.XLEN(XLEN)) u_cmp (
    .lhs_i  (rs1_val_i),
    .rhs_i  (rs2_val_i),
    .mode_i (cmp_e'(funct3)),
    .hit_o  (cond_hit)
  );

  assign seq_pc  = pc_i + STEP;
  assign ind_sum = rs1_val_i + imm_i;

  always_comb begin
    taken_o = 1'b0;
    target  = seq_pc;
    unique case (flow)
      FLOW_BRANCH: begin taken_o = cond_hit; target = pc_i + imm_b; end
      FLOW_JAL:    begin taken_o = 1'b1;     target = pc_i + imm_j; end
      FLOW_JALR:   begin taken_o = 1'b1;     target = {ind_sum[XLEN-1:1], 1'b0}; end
      default:     begin taken_o = 1'b0;     target = seq_pc; end
    endcase
  end

  assign next_pc_o  = taken_o ? target : seq_pc;
  assign link_val_o = seq_pc;
  assign link_we_o  = (flow == FLOW_JAL || flow == FLOW_JALR) && (rd != 5'd0);

  always_comb begin
    // R1
    seq_path_chk: assert (opcode == OP_BRANCH || opcode == OP_JAL || opcode == OP_JALR
                          || (!taken_o && next_pc_o == pc_i + STEP && !link_we_o))
      else $error("non-control opcode left the sequential path");
    // R3
    jalr_even_chk: assert (!(opcode == OP_JALR && funct3 == 3'b000) || next_pc_o[0] == 1'b0)
      else $error("indirect jump target is odd");
    // R9
    link_we_chk: assert (!link_we_o || ((opcode == OP_JAL || opcode == OP_JALR) && rd != 5'd0))
      else $error("return address write outside a jump");
    // R2
    jal_taken_chk: assert (opcode != OP_JAL || (taken_o && next_pc_o[0] == pc_i[0]))
      else $error("direct jump not redirected or odd offset");
  end
endmodule

// File: tb/npc_unit_bench.sv
module npc_unit_bench;
  localparam int XLEN = 32;

  typedef struct {
    logic [31:0] exp_next;
    logic        exp_taken;
    logic [31:0] exp_link;
    logic        exp_we;
    string       tag;
  } item_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [31:0] pc, instr, rs1, rs2;
  logic [31:0] next_pc, link_val;
  logic        taken, link_we;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  item_t sb_q[$];

  npc_unit #(.XLEN(XLEN)) u_npc_unit (
    .pc_i       (pc),
    .instr_i    (instr),
    .rs1_val_i  (rs1),
    .rs2_val_i  (rs2),
    .next_pc_o  (next_pc),
    .taken_o    (taken),
    .link_val_o (link_val),
    .link_we_o  (link_we)
  );

  function automatic logic [31:0] enc_b(logic [2:0] f3, int imm);
    logic [12:0] m = imm[12:0];
    return {m[12], m[10:5], 5'd2, 5'd1, f3, m[4:1], m[11], 7'b1100011};
  endfunction

  function automatic logic [31:0] enc_j(logic [4:0] rd, int imm);
    logic [20:0] m = imm[20:0];
    return {m[20], m[10:1], m[11], m[19:12], rd, 7'b1101111};
  endfunction

  function automatic logic [31:0] enc_r(logic [4:0] rd, logic [2:0] f3, int imm);
    logic [11:0] m = imm[11:0];
    return {m, 5'd1, f3, rd, 7'b1100111};
  endfunction

  task automatic apply(input logic [31:0] p, input logic [31:0] ins,
                       input logic [31:0] a, input logic [31:0] b,
                       input logic [31:0] nx, input logic tk,
                       input logic we, input string tag);
    item_t it;
    @(negedge clk);
    pc = p; instr = ins; rs1 = a; rs2 = b;
    it.exp_next = nx; it.exp_taken = tk; it.exp_link = p + 32'd4;
    it.exp_we = we; it.tag = tag;
    sb_q.push_back(it);
  endtask

  always @(posedge clk) begin
    if (rst_n && sb_q.size() > 0) begin
      item_t it;
      it = sb_q.pop_front();
      checks++;
      if (next_pc !== it.exp_next || taken !== it.exp_taken ||
          link_val !== it.exp_link || link_we !== it.exp_we) begin
        fails++;
        $display("FAIL %s: next=%h taken=%b link=%h we=%b expected next=%h taken=%b link=%h we=%b",
                 it.tag, next_pc, taken, link_val, link_we,
                 it.exp_next, it.exp_taken, it.exp_link, it.exp_we);
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    pc = 0; instr = 0; rs1 = 0; rs2 = 0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    // R1: reset-time state, all-zero instruction, and an ALU instruction
    apply(32'h0, 32'h0, 0, 0, 32'h4, 0, 0, "R1 reset state");
    apply(32'h100, 32'h00c58533, 5, 7, 32'h104, 0, 0, "R1 alu falls through");
    // R2: direct jumps
    apply(32'h1000, enc_j(5'd1, 2048), 0, 0, 32'h1800, 1, 1, "R2 jal +2048");
    apply(32'h1000, enc_j(5'd5, -4), 0, 0, 32'hffc, 1, 1, "R2 jal -4");
    apply(32'h40000, enc_j(5'd3, 32'h12346), 0, 0, 32'h52346, 1, 1, "R2 jal mid fields");
    apply(32'h200000, enc_j(5'd3, -1048576), 0, 0, 32'h100000, 1, 1, "R2 jal most negative");
    // R9: destination zero keeps the write off
    apply(32'h1000, enc_j(5'd0, 16), 0, 0, 32'h1010, 1, 0, "R9 jal rd zero");
    apply(32'h1000, enc_r(5'd0, 3'b000, 8), 32'h3000, 0, 32'h3008, 1, 0, "R9 jalr rd zero");
    // R3: indirect jumps
    apply(32'h500, enc_r(5'd1, 3'b000, -1), 32'h2001, 0, 32'h2000, 1, 1, "R3 jalr clears bit0");
    apply(32'h500, enc_r(5'd2, 3'b000, 2047), 32'h3000, 0, 32'h37fe, 1, 1, "R3 jalr +2047");
    apply(32'h500, enc_r(5'd2, 3'b001, 64), 32'h3000, 0, 32'h504, 0, 0, "R3 jalr bad funct3");
    // R4: equality branches
    apply(32'h800, enc_b(3'b000, 16), 9, 9, 32'h810, 1, 0, "R4 beq equal");
    apply(32'h800, enc_b(3'b000, 16), 9, 8, 32'h804, 0, 0, "R4 beq differ");
    apply(32'h800, enc_b(3'b001, -8), 9, 9, 32'h804, 0, 0, "R4 bne equal");
    apply(32'h800, enc_b(3'b001, -8), 9, 3, 32'h7f8, 1, 0, "R4 bne differ");
    // R5: signed compares
    apply(32'h800, enc_b(3'b100, 32), 32'hffffffff, 1, 32'h820, 1, 0, "R5 blt -1<1");
    apply(32'h800, enc_b(3'b100, 32), 1, 32'hffffffff, 32'h804, 0, 0, "R5 blt 1<-1");
    apply(32'h800, enc_b(3'b101, 32), 32'hffffffff, 1, 32'h804, 0, 0, "R5 bge -1>=1");
    apply(32'h800, enc_b(3'b101, 32), 7, 7, 32'h820, 1, 0, "R5 bge equal");
    // R6: unsigned compares
    apply(32'h800, enc_b(3'b110, 64), 32'hffffffff, 1, 32'h804, 0, 0, "R6 bltu max<1");
    apply(32'h800, enc_b(3'b110, 64), 1, 2, 32'h840, 1, 0, "R6 bltu 1<2");
    apply(32'h800, enc_b(3'b111, 64), 32'hffffffff, 1, 32'h840, 1, 0, "R6 bgeu max>=1");
    apply(32'h800, enc_b(3'b111, 64), 1, 2, 32'h804, 0, 0, "R6 bgeu 1>=2");
    // R7: reserved branch codes
    apply(32'h800, enc_b(3'b010, 64), 4, 4, 32'h804, 0, 0, "R7 funct3 010");
    apply(32'h800, enc_b(3'b011, 64), 1, 9, 32'h804, 0, 0, "R7 funct3 011");
    // R8: offset extremes
    apply(32'h2000, enc_b(3'b000, -4096), 0, 0, 32'h1000, 1, 0, "R8 branch -4096");
    apply(32'h2000, enc_b(3'b000, 4094), 0, 0, 32'h2ffe, 1, 0, "R8 branch +4094");
    apply(32'h2000, enc_b(3'b000, 2048), 0, 0, 32'h2800, 1, 0, "R8 branch bit11");
    // R10: wrap-around
    apply(32'hfffffffc, 32'h00000013, 0, 0, 32'h0, 0, 0, "R10 sequential wrap");
    apply(32'hfffffffc, enc_j(5'd1, 8), 0, 0, 32'h4, 1, 1, "R10 jal wrap");
    apply(32'h4, enc_b(3'b000, -8), 0, 0, 32'hfffffffc, 1, 0, "R10 branch wrap");

    while (sb_q.size() > 0) @(posedge clk);
    @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule